// File: doc/BRIEF.md
# Pointer Address Generator for a Signal-Processing Core

This block forms memory addresses for a signal-processing core without using its arithmetic datapath. It holds a small file of pointer registers, each with a companion base and length register. On every clock the core may issue one address request. The request names a pointer, an addressing mode, a step and a direction. The block returns the address one cycle later and, in the same clock edge, writes back the updated pointer. The next request therefore already sees the new value.

Linear stepping can update the pointer after the address is taken or before it. Two circular forms remove the end-of-buffer checks from inner loops. One works on any window given by a base and a length. The other needs an aligned window of power-of-two size and wraps only the low bits. A reverse-carry mode walks radix-2 FFT data in bit-reversed order. Configuration writes load the pointer, base and length registers.

Top module: `agu_top`

## Requirements
- R1: After reset every pointer, base and length register is zero, `addrValid` is low and `addrOut` is zero.
- R2: A request accepted on a clock edge shows its address on `addrOut` with `addrValid` high for exactly the following cycle. `addrValid` is low after any cycle without a request.
- R3: Mode code 0 (indirect) emits the pointer and leaves it unchanged. The unused codes 6 and 7 behave exactly like code 0.
- R4: Mode code 1 (post-modify) emits the old pointer. It then writes back pointer + step, or pointer - step when `reqDown` is 1, modulo 2^AW.
- R5: Mode code 2 (pre-modify) computes pointer ± step as in R4, emits that value and writes it back.
- R6: Mode code 3 (circular) emits the old pointer. Counting up, the new value is pointer + step; if that reaches base + length or beyond, length is subtracted. This requires step ≤ length.
- R7: In mode code 3 counting down, when pointer - step falls below base the new pointer is pointer - step + length. A pointer sitting at base therefore moves to base + length - step.
- R8: Mode code 4 (bit-reversed) emits the old pointer. It adds the step, or subtracts it when `reqDown` is 1, in the low K bits of the pointer, with the carry running from the top of that field toward bit 0. K is the low 5 bits of the length register. Bits at and above K are kept. With K=3 and step 4, a walk from offset 0 visits 0,4,2,6,1,5,3,7 and then returns to 0.
- R9: Mode code 5 (aligned modulo) emits the old pointer. Length must be a power of two L. The new pointer keeps the bits above log2(L) and takes the low log2(L) bits of pointer ± step.
- R10: Requests on consecutive cycles each see the pointer left by the previous request. Requests to different pointers do not disturb one another.
- R11: A configuration write selects the target with `cfgSel`: 0 = pointer, 1 = base, 2 = length. Code 3 changes nothing. A pointer write in the same cycle as a request updating that pointer wins, while the request still emits the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Address request strobe |
| reqIdx | input | 2 | Pointer register selected by the request |
| reqMode | input | 3 | Addressing mode code |
| reqStep | input | 16 | Step magnitude |
| reqDown | input | 1 | 1 = subtract the step, 0 = add it |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Configuration target: pointer, base or length |
| cfgIdx | input | 2 | Register set written |
| cfgData | input | 16 | Configuration write value |
| addrValid | output | 1 | Address on `addrOut` is valid |
| addrOut | output | 16 | Emitted address |

## Verification
The bench drives the circular window across its upper end and below its base. A design that compares with the wrong bound or drops the length correction would wander out of the buffer or stop one entry short. It walks the full eight-point bit-reversed sequence both ways. A normal-carry adder would produce 0,4,0,4 instead of the scattered order. It also checks that aligned wrap keeps the upper bits of the pointer. The bench issues requests back to back on interleaved pointers, so a design that used a stale pointer or mixed up register sets would repeat or swap addresses. It also makes a configuration write collide with a request update and uses the unused codes, so a wrong priority or a stray update would leave a different pointer behind.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [2:0] {
    MODE_IND   = 3'd0,
    MODE_POST  = 3'd1,
    MODE_PRE   = 3'd2,
    MODE_CIRC  = 3'd3,
    MODE_BREV  = 3'd4,
    MODE_ALIGN = 3'd5
  } agu_mode_e;

  typedef enum logic [2:0] {
    UPD_NONE,
    UPD_LIN,
    UPD_CIRC,
    UPD_BREV,
    UPD_ALIGN
  } upd_kind_e;

  typedef struct packed {
    logic      fire;
    logic      preForm;
    logic      down;
    upd_kind_e kind;
    logic      cfgPtr;
    logic      cfgBase;
    logic      cfgLen;
  } agu_strobe_t;

endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [2:0]  reqMode,
  input  logic        reqDown,
  input  logic        cfgWe,
  input  logic [1:0]  cfgSel,
  output agu_strobe_t strobe,
  output logic        addrValid
);

  always_comb begin
    strobe         = '0;
    strobe.fire    = reqValid;
    strobe.down    = reqDown;
    strobe.kind    = UPD_NONE;
    if (reqValid) begin
      unique case (reqMode)
        MODE_POST:  strobe.kind = UPD_LIN;
        MODE_PRE: begin
          strobe.kind    = UPD_LIN;
          strobe.preForm = 1'b1;
        end
        MODE_CIRC:  strobe.kind = UPD_CIRC;
        MODE_BREV:  strobe.kind = UPD_BREV;
        MODE_ALIGN: strobe.kind = UPD_ALIGN;
        default:    strobe.kind = UPD_NONE;
      endcase
    end
    strobe.cfgPtr  = cfgWe && (cfgSel == 2'd0);
    strobe.cfgBase = cfgWe && (cfgSel == 2'd1);
    strobe.cfgLen  = cfgWe && (cfgSel == 2'd2);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrValid <= 1'b0;
    else       addrValid <= reqValid;
  end

endmodule

// File: rtl/agu_datapath.sv
module agu_datapath
  import agu_pkg::*;
#(
  parameter int AW      = 16,
  parameter int NUM_PTR = 4,
  localparam int IW     = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1,
  localparam int FW     = $clog2(AW + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  agu_strobe_t    strobe,
  input  logic [IW-1:0]  reqIdx,
  input  logic [AW-1:0]  reqStep,
  input  logic [IW-1:0]  cfgIdx,
  input  logic [AW-1:0]  cfgData,
  output logic [AW-1:0]  addrOut
);

  logic [AW-1:0] ptrQ  [NUM_PTR];
  logic [AW-1:0] baseQ [NUM_PTR];
  logic [AW-1:0] lenQ  [NUM_PTR];

  logic [AW-1:0] curPtr, curBase, curLen;
  logic [AW-1:0] linNext, circNext, brevNext, alignNext, nextPtr, emitAddr;

  function automatic logic [AW-1:0] revField(input logic [AW-1:0] x, input int k);
    logic [AW-1:0] r;
    r = '0;
    for (int i = 0; i < AW; i++) begin
      if (i < k) r[i] = x[k-1-i];
    end
    return r;
  endfunction

  assign curPtr  = ptrQ[reqIdx];
  assign curBase = baseQ[reqIdx];
  assign curLen  = lenQ[reqIdx];

  // linear step, modulo 2^AW
  assign linNext = strobe.down ? (curPtr - reqStep) : (curPtr + reqStep);

  // circular window [base, base+len)
  logic [AW:0] offUp, offDn, lenW, stepW;
  always_comb begin
    lenW  = {1'b0, curLen};
    stepW = {1'b0, reqStep};
    offUp = {1'b0, curPtr - curBase} + stepW;
    offDn = {1'b0, curPtr - curBase};
    if (!strobe.down) begin
      if (offUp >= lenW) circNext = curPtr + reqStep - curLen;
      else               circNext = curPtr + reqStep;
    end else begin
      if (offDn < stepW) circNext = curPtr - reqStep + curLen;
      else               circNext = curPtr - reqStep;
    end
  end

  // reverse-carry step inside the low K bits
  int            fieldK;
  logic [AW-1:0] fieldMask, revPtr, revStep, revSum;
  always_comb begin
    fieldK = int'(curLen[FW-1:0]);
    if (fieldK > AW) fieldK = AW;
    fieldMask = '0;
    for (int i = 0; i < AW; i++) begin
      if (i < fieldK) fieldMask[i] = 1'b1;
    end
    revPtr   = revField(curPtr, fieldK);
    revStep  = revField(reqStep, fieldK);
    revSum   = strobe.down ? (revPtr - revStep) : (revPtr + revStep);
    brevNext = (curPtr & ~fieldMask) | (revField(revSum, fieldK) & fieldMask);
  end

  // aligned power-of-two window
  logic [AW-1:0] alignMask;
  assign alignMask = curLen - 1'b1;
  assign alignNext = (curPtr & ~alignMask) | (linNext & alignMask);

  always_comb begin
    unique case (strobe.kind)
      UPD_LIN:   nextPtr = linNext;
      UPD_CIRC:  nextPtr = circNext;
      UPD_BREV:  nextPtr = brevNext;
      UPD_ALIGN: nextPtr = alignNext;
      default:   nextPtr = curPtr;
    endcase
    emitAddr = strobe.preForm ? nextPtr : curPtr;
  end

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_regs
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ptrQ[g]  <= '0;
        baseQ[g] <= '0;
        lenQ[g]  <= '0;
      end else begin
        if (strobe.cfgPtr && cfgIdx == IW'(g))
          ptrQ[g] <= cfgData;
        else if (strobe.fire && reqIdx == IW'(g))
          ptrQ[g] <= nextPtr;
        if (strobe.cfgBase && cfgIdx == IW'(g)) baseQ[g] <= cfgData;
        if (strobe.cfgLen  && cfgIdx == IW'(g)) lenQ[g]  <= cfgData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            addrOut <= '0;
    else if (strobe.fire) addrOut <= emitAddr;
  end

endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int AW      = 16,
  parameter int NUM_PTR = 4,
  localparam int IW     = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [IW-1:0] reqIdx,
  input  logic [2:0]    reqMode,
  input  logic [AW-1:0] reqStep,
  input  logic          reqDown,
  input  logic          cfgWe,
  input  logic [1:0]    cfgSel,
  input  logic [IW-1:0] cfgIdx,
  input  logic [AW-1:0] cfgData,
  output logic          addrValid,
  output logic [AW-1:0] addrOut
);

  agu_strobe_t strobe;

  agu_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqMode   (reqMode),
    .reqDown   (reqDown),
    .cfgWe     (cfgWe),
    .cfgSel    (cfgSel),
    .strobe    (strobe),
    .addrValid (addrValid)
  );

  agu_datapath #(.AW(AW), .NUM_PTR(NUM_PTR)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqIdx  (reqIdx),
    .reqStep (reqStep),
    .cfgIdx  (cfgIdx),
    .cfgData (cfgData),
    .addrOut (addrOut)
  );

endmodule

// File: rtl/agu_top_check.sv
module agu_top_check #(
  parameter int AW = 16,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqValid,
  input logic [IW-1:0] reqIdx,
  input logic [2:0]    reqMode,
  input logic [AW-1:0] reqStep,
  input logic          reqDown,
  input logic          cfgWe,
  input logic          addrValid,
  input logic [AW-1:0] addrOut
);

  // R2: a request is answered on the next cycle
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> addrValid);

  // R2: no request, no valid address
  p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !addrValid);

  // R3: indirect or unused codes never move the pointer
  p_ind_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !cfgWe && (reqMode == 3'd0 || reqMode >= 3'd6))
    ##1 (reqValid && reqMode == 3'd0 && reqIdx == $past(reqIdx))
    |=> $stable(addrOut));

  // R4: post-modify up advances the pointer by the step
  p_post_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !cfgWe && reqMode == 3'd1 && !reqDown)
    ##1 (reqValid && reqMode == 3'd0 && reqIdx == $past(reqIdx))
    |=> addrOut == $past(addrOut) + $past(reqStep, 2));

  // R5: pre-modify emits the stepped value, indirect after it repeats it
  p_pre_repeat_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !cfgWe && reqMode == 3'd2)
    ##1 (reqValid && reqMode == 3'd0 && reqIdx == $past(reqIdx))
    |=> $stable(addrOut));

endmodule

bind agu_top agu_top_check #(.AW(AW), .IW(IW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqIdx    (reqIdx),
  .reqMode   (reqMode),
  .reqStep   (reqStep),
  .reqDown   (reqDown),
  .cfgWe     (cfgWe),
  .addrValid (addrValid),
  .addrOut   (addrOut)
);

// File: tb/agu_top_bench.sv
module agu_top_bench;

  localparam int AW = 16;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [IW-1:0] reqIdx = '0;
  logic [2:0]    reqMode = '0;
  logic [AW-1:0] reqStep = '0;
  logic          reqDown = 1'b0;
  logic          cfgWe = 1'b0;
  logic [1:0]    cfgSel = '0;
  logic [IW-1:0] cfgIdx = '0;
  logic [AW-1:0] cfgData = '0;
  logic          addrValid;
  logic [AW-1:0] addrOut;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  agu_top #(.AW(AW), .NUM_PTR(4)) u_agu_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIdx(reqIdx),
    .reqMode(reqMode), .reqStep(reqStep), .reqDown(reqDown),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .addrValid(addrValid), .addrOut(addrOut)
  );

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // called at a negative edge; returns at the next negative edge
  task automatic req(input int idx, input int mode, input int step, input bit down,
                     input int expAddr, input string tag);
    reqValid = 1'b1; reqIdx = IW'(idx); reqMode = 3'(mode);
    reqStep = AW'(step); reqDown = down;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    check({tag, " valid"}, int'(addrValid), 1);
    check(tag, int'(addrOut), expAddr);
  endtask

  task automatic cfg(input int sel, input int idx, input int data);
    cfgWe = 1'b1; cfgSel = 2'(sel); cfgIdx = IW'(idx); cfgData = AW'(data);
    @(posedge clk); @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 addrValid after reset", int'(addrValid), 0);
    check("R1 addrOut after reset", int'(addrOut), 0);
    req(0, 0, 0, 0, 0, "R1 pointer0 zero");
    req(3, 0, 0, 0, 0, "R1 pointer3 zero");
    @(negedge clk);
    check("R2 valid drops when idle", int'(addrValid), 0);
  endtask

  task automatic t_linear();
    cfg(0, 0, 10);
    req(0, 1, 1, 0, 10, "R4 post up first");
    req(0, 1, 1, 0, 11, "R4 post up second");
    req(0, 2, 3, 0, 15, "R5 pre up");
    req(0, 1, 5, 1, 15, "R4 post down");
    req(0, 0, 0, 0, 10, "R4 after post down");
    req(0, 2, 20, 1, 65526, "R5 pre down wraps modulo");
    req(0, 0, 0, 0, 65526, "R5 pointer written back");
  endtask

  task automatic t_indirect();
    cfg(0, 1, 77);
    req(1, 0, 9, 0, 77, "R3 indirect");
    req(1, 6, 9, 0, 77, "R3 code6 emits pointer");
    req(1, 7, 9, 1, 77, "R3 code7 emits pointer");
    req(1, 0, 0, 0, 77, "R3 unused codes left pointer");
  endtask

  task automatic t_circ();
    cfg(1, 2, 100); cfg(2, 2, 5); cfg(0, 2, 100);
    req(2, 3, 2, 0, 100, "R6 circ 0");
    req(2, 3, 2, 0, 102, "R6 circ 1");
    req(2, 3, 2, 0, 104, "R6 circ 2");
    req(2, 3, 2, 0, 101, "R6 circ wrap");
    req(2, 3, 2, 0, 103, "R6 circ 4");
    req(2, 3, 1, 1, 100, "R6 circ wrap back to base");
    req(2, 0, 0, 0, 104, "R7 below base wraps to end");
    req(2, 3, 3, 1, 104, "R7 down inside window");
    req(2, 0, 0, 0, 101, "R7 plain decrement");
  endtask

  task automatic t_brev();
    int order[8] = '{0, 4, 2, 6, 1, 5, 3, 7};
    cfg(2, 3, 3); cfg(0, 3, 16'h200);
    for (int i = 0; i < 8; i++)
      req(3, 4, 4, 0, 16'h200 + order[i], $sformatf("R8 bitrev step %0d", i));
    req(3, 0, 0, 0, 16'h200, "R8 bitrev returns to start");
    req(3, 4, 4, 1, 16'h200, "R8 bitrev down");
    req(3, 0, 0, 0, 16'h207, "R8 reverse borrow keeps upper bits");
  endtask

  task automatic t_align();
    cfg(2, 1, 8); cfg(0, 1, 16'h46);
    req(1, 5, 3, 0, 16'h46, "R9 aligned 0");
    req(1, 5, 3, 0, 16'h41, "R9 aligned wrap keeps upper");
    req(1, 5, 3, 1, 16'h44, "R9 aligned down");
    req(1, 5, 3, 1, 16'h41, "R9 aligned down wrap");
    req(1, 0, 0, 0, 16'h46, "R9 aligned final");
  endtask

  task automatic t_interleave();
    cfg(0, 0, 50); cfg(0, 2, 70); cfg(2, 2, 0);
    req(0, 1, 1, 0, 50, "R10 ptr0 first");
    req(2, 1, 2, 0, 70, "R10 ptr2 first");
    req(0, 1, 1, 0, 51, "R10 ptr0 sees update");
    req(2, 1, 2, 0, 72, "R10 ptr2 sees update");
  endtask

  task automatic t_cfg();
    cfg(0, 3, 7);
    cfgWe = 1'b1; cfgSel = 2'd0; cfgIdx = 2'd3; cfgData = 16'd500;
    req(3, 1, 1, 0, 7, "R11 collision emits old");
    cfgWe = 1'b0;
    req(3, 0, 0, 0, 500, "R11 config wins collision");
    cfg(3, 3, 999);
    req(3, 0, 0, 0, 500, "R11 code3 ignored");
    cfg(1, 3, 40);
    req(3, 0, 0, 0, 500, "R11 base write leaves pointer");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_linear();
    t_indirect();
    t_circ();
    t_brev();
    t_align();
    t_interleave();
    t_cfg();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule